// File: doc/BRIEF.md
# Serial Clock Register File with Time Snapshot

This block is the byte-level register side of a serial real-time clock that also holds battery-backed RAM. A bus target front end, which is not part of this block, decodes the wire protocol and presents four single-cycle strobes: start of a write transfer, start of a read transfer, a received data byte, and a request for the next byte to send. Behind those strobes the block keeps a 64-byte space addressed by a 6-bit pointer that advances by one on every data byte.

Bytes 0 to 6 hold a frozen copy of the running time, taken from a separate timekeeping counter. The block refreshes the copy on every start condition and again whenever the pointer rolls over, so a multi-byte read always returns one coherent time. Writes to those seven bytes do not touch the copy. Instead they become a one-cycle load request to the timekeeper, carrying the field index and the byte. Byte 7 is a control register with reserved bits held at zero and an oscillator-stop flag that software can clear but never set. Only a stop indication from the oscillator monitor can set it. Bytes 8 to 63 are plain RAM.

Top module: `rtc_regfile`

## Requirements
- R1: While reset is high and after it is released, the pointer, the expect-address flag and all 64 bytes are zero, and `rd_valid_o` and `tk_load_o` are low.
- R2: The first data byte after a start-of-write sets the pointer to that byte's low 6 bits. The byte is not stored and causes no load request.
- R3: Each data byte written and each byte read advances the pointer by one. The pointer rolls from 63 to 0.
- R4: When the pointer rolls to 0 on a data byte, bytes 0 to 6 are refreshed from `time_i`. Byte k is taken from `time_i[8k+7:8k]`.
- R5: A start-of-read or start-of-write refreshes bytes 0 to 6 from `time_i`. Reads of those bytes return the frozen copy, even after `time_i` has moved on.
- R6: A write to address 7 keeps only the bits under mask 0xB3. Bits 6, 3 and 2 of address 7 always read as zero.
- R7: In a write to address 7, a 1 in bit 5 (oscillator stop) leaves that bit unchanged and a 0 clears it. A high `osc_stop_i` sets bit 5 and wins over a write in the same cycle.
- R8: A write to address k, with k from 0 to 6, gives a one-cycle `tk_load_o` pulse in the next cycle, with `tk_field_o` = k and `tk_data_o` = the byte. Bytes 0 to 6 of the register space keep their value.
- R9: A write to any address from 8 to 63 stores the byte unchanged, and a later read returns it.
- R10: Read data is registered. `rd_data_o` and a one-cycle `rd_valid_o` appear in the cycle after `rd_stb_i` and show the byte at the pointer as it was when the strobe arrived.
- R11: A start strobe takes priority over a data strobe in the same cycle. The data strobe is then ignored: it does not move the pointer, store a byte or raise `rd_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_wr_i | input | 1 | Start condition of a write transfer |
| start_rd_i | input | 1 | Start condition of a read transfer |
| wr_stb_i | input | 1 | Received data byte is valid |
| wr_data_i | input | 8 | Received data byte |
| rd_stb_i | input | 1 | Request for the byte to send |
| rd_data_o | output | 8 | Registered read byte |
| rd_valid_o | output | 1 | `rd_data_o` is valid for this cycle |
| time_i | input | 56 | Live time from the timekeeper, seven bytes, field k at bits 8k+7:8k |
| osc_stop_i | input | 1 | Oscillator monitor reports a stop; sets the stop flag |
| tk_load_o | output | 1 | Load request to the timekeeper |
| tk_field_o | output | 3 | Index of the time field to load |
| tk_data_o | output | 8 | Value to load into that field |

## Verification
The assertions check, on every cycle, the per-byte rules: the pointer moves by one or takes the address byte, the snapshot equals the time seen at the capture edge, the control register's reserved bits stay zero, the stop flag never rises without the monitor input, and read and load pulses follow their strobes by one cycle. Whether the frozen copy is really what a read returns after the live time has moved, what the stop flag does across a sequence of writes, and how rollover and start priority interact with stored RAM are shown only by the bench's scenarios. The bench checks those against its own byte-array model at every clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W     = 6;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int TIME_BYTES = 7;
    localparam int FIELD_W    = $clog2(TIME_BYTES);
    localparam int CTRL_ADDR  = 7;
    localparam logic [7:0] CTRL_KEEP = 8'hB3;
    localparam int STOP_BIT   = 5;
    localparam logic [7:0] STOP_MASK = 8'(1 << STOP_BIT);

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_ADDR,
        OP_WRITE,
        OP_READ
    } op_e;

    typedef struct packed {
        logic              capture;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        byte_t             data;
    } access_t;

    // Control write: reserved bits dropped, stop flag may only fall.
    function automatic byte_t ctrl_merge(input byte_t old_v, input byte_t new_v);
        byte_t kept;
        kept = new_v & CTRL_KEEP & ~STOP_MASK;
        return kept | (new_v & old_v & STOP_MASK);
    endfunction

endpackage

// File: rtl/rtc_ptr.sv
module rtc_ptr
    import rtc_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_wr_i,
    input  logic          start_rd_i,
    input  logic          wr_stb_i,
    input  byte_t         wr_data_i,
    input  logic          rd_stb_i,
    output access_t       acc_o
);

    localparam logic [AW-1:0] PTR_LAST = '1;

    logic [AW-1:0] ptr_q;
    logic          expect_q;
    op_e           op;

    always_comb begin
        op = OP_NONE;
        if (start_wr_i || start_rd_i) begin
            op = OP_NONE;
        end else if (wr_stb_i) begin
            op = expect_q ? OP_ADDR : OP_WRITE;
        end else if (rd_stb_i) begin
            op = OP_READ;
        end
    end

    always_comb begin
        acc_o.op      = op;
        acc_o.addr    = ptr_q;
        acc_o.data    = wr_data_i;
        acc_o.capture = start_wr_i || start_rd_i ||
                        (((op == OP_WRITE) || (op == OP_READ)) && (ptr_q == PTR_LAST));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q    <= '0;
            expect_q <= 1'b0;
        end else if (start_wr_i) begin
            expect_q <= 1'b1;
        end else if (start_rd_i) begin
            expect_q <= 1'b0;
        end else begin
            case (op)
                OP_ADDR: begin
                    ptr_q    <= wr_data_i[AW-1:0];
                    expect_q <= 1'b0;
                end
                OP_WRITE, OP_READ: ptr_q <= ptr_q + 1'b1;
                default: ;
            endcase
        end
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        ((op == OP_WRITE) || (op == OP_READ)) |=> (ptr_q == $past(ptr_q) + 1'b1)) // R3
        else $error("pointer did not step");

    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_stb_i && expect_q && !start_wr_i && !start_rd_i)
        |=> (ptr_q == $past(wr_data_i[AW-1:0])) && !expect_q) // R2
        else $error("address byte not taken");

    AST_START_HOLDS_PTR: assert property (@(posedge clk) disable iff (rst)
        (start_wr_i || start_rd_i) |=> $stable(ptr_q)) // R11
        else $error("pointer moved on start");

endmodule

// File: rtl/rtc_store.sv
module rtc_store
    import rtc_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int NTIME = TIME_BYTES,
    parameter int CADDR = CTRL_ADDR
) (
    input  logic            clk,
    input  logic            rst,
    input  access_t         acc_i,
    input  logic [8*NTIME-1:0] time_i,
    input  logic            osc_stop_i,
    output byte_t           rd_data_o,
    output logic            rd_valid_o
);

    localparam int NBYTES = 1 << AW;

    byte_t              cells [NBYTES];
    logic [8*NTIME-1:0] snap_flat;
    byte_t              rd_q;
    logic               rv_q;

    for (genvar g = 0; g < NBYTES; g++) begin : g_cell
        byte_t cell_q;
        logic  hit;
        assign hit      = (acc_i.op == OP_WRITE) && (acc_i.addr == AW'(g));
        assign cells[g] = cell_q;

        if (g < NTIME) begin : g_time
            always_ff @(posedge clk) begin
                if (rst) begin
                    cell_q <= '0;
                end else if (acc_i.capture) begin
                    cell_q <= time_i[8*g +: 8];
                end
            end
            assign snap_flat[8*g +: 8] = cell_q;
        end else if (g == CADDR) begin : g_ctrl
            always_ff @(posedge clk) begin
                if (rst) begin
                    cell_q <= '0;
                end else begin
                    if (hit) begin
                        cell_q <= ctrl_merge(cell_q, acc_i.data);
                    end
                    if (osc_stop_i) begin
                        cell_q[STOP_BIT] <= 1'b1;
                    end
                end
            end

            AST_CTRL_RSVD: assert property (@(posedge clk) disable iff (rst)
                ((cell_q & ~CTRL_KEEP) == 8'h00)) // R6
                else $error("reserved control bit set");

            AST_STOP_NO_SET: assert property (@(posedge clk) disable iff (rst)
                (!cell_q[STOP_BIT] && !osc_stop_i) |=> !cell_q[STOP_BIT]) // R7
                else $error("stop flag rose without monitor");
        end else begin : g_ram
            always_ff @(posedge clk) begin
                if (rst) begin
                    cell_q <= '0;
                end else if (hit) begin
                    cell_q <= acc_i.data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
            rv_q <= 1'b0;
        end else begin
            rv_q <= (acc_i.op == OP_READ);
            if (acc_i.op == OP_READ) begin
                rd_q <= cells[acc_i.addr];
            end
        end
    end

    assign rd_data_o  = rd_q;
    assign rd_valid_o = rv_q;

    AST_SNAP_TAKEN: assert property (@(posedge clk) disable iff (rst)
        acc_i.capture |=> (snap_flat == $past(time_i))) // R5
        else $error("snapshot differs from captured time");

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
        (acc_i.op == OP_READ) |=> rv_q) // R10
        else $error("read valid missing");

    AST_RD_ONLY_ON_STB: assert property (@(posedge clk) disable iff (rst)
        (acc_i.op != OP_READ) |=> !rv_q) // R10
        else $error("spurious read valid");

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start_wr_i,
    input  logic         start_rd_i,
    input  logic         wr_stb_i,
    input  logic [7:0]   wr_data_i,
    input  logic         rd_stb_i,
    output logic [7:0]   rd_data_o,
    output logic         rd_valid_o,
    input  logic [55:0]  time_i,
    input  logic         osc_stop_i,
    output logic         tk_load_o,
    output logic [2:0]   tk_field_o,
    output logic [7:0]   tk_data_o
);

    access_t              acc;
    logic                 tk_load_q;
    logic [FIELD_W-1:0]   tk_field_q;
    byte_t                tk_data_q;

    rtc_ptr #(.AW(ADDR_W)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .start_wr_i (start_wr_i),
        .start_rd_i (start_rd_i),
        .wr_stb_i   (wr_stb_i),
        .wr_data_i  (wr_data_i),
        .rd_stb_i   (rd_stb_i),
        .acc_o      (acc)
    );

    rtc_store #(.AW(ADDR_W), .NTIME(TIME_BYTES), .CADDR(CTRL_ADDR)) u_store (
        .clk        (clk),
        .rst        (rst),
        .acc_i      (acc),
        .time_i     (time_i),
        .osc_stop_i (osc_stop_i),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tk_load_q  <= 1'b0;
            tk_field_q <= '0;
            tk_data_q  <= '0;
        end else begin
            tk_load_q <= (acc.op == OP_WRITE) && (acc.addr < ADDR_W'(TIME_BYTES));
            if ((acc.op == OP_WRITE) && (acc.addr < ADDR_W'(TIME_BYTES))) begin
                tk_field_q <= acc.addr[FIELD_W-1:0];
                tk_data_q  <= acc.data;
            end
        end
    end

    assign tk_load_o  = tk_load_q;
    assign tk_field_o = tk_field_q;
    assign tk_data_o  = tk_data_q;

    AST_TK_FIELD_RANGE: assert property (@(posedge clk) disable iff (rst)
        tk_load_o |-> (tk_field_o < 3'(TIME_BYTES))) // R8
        else $error("load request for a non-time field");

    AST_TK_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        !wr_stb_i |=> !tk_load_o) // R8
        else $error("load request without a write");

endmodule

// File: tb/sim_rtc_regfile.sv
module sim_rtc_regfile;

    localparam int K_IDLE = 0;
    localparam int K_SWR  = 1;
    localparam int K_SRD  = 2;
    localparam int K_WR   = 3;
    localparam int K_RD   = 4;
    localparam int K_OSC  = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_wr_i = 1'b0;
    logic        start_rd_i = 1'b0;
    logic        wr_stb_i = 1'b0;
    logic [7:0]  wr_data_i = 8'h00;
    logic        rd_stb_i = 1'b0;
    logic [7:0]  rd_data_o;
    logic        rd_valid_o;
    logic [55:0] time_i = 56'h0;
    logic        osc_stop_i = 1'b0;
    logic        tk_load_o;
    logic [2:0]  tk_field_o;
    logic [7:0]  tk_data_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model
    logic [7:0] m [64];
    int  ptr = 0;
    bit  expect_addr = 0;

    always #2 clk = ~clk;

    rtc_regfile u0 (
        .clk(clk), .rst(rst),
        .start_wr_i(start_wr_i), .start_rd_i(start_rd_i),
        .wr_stb_i(wr_stb_i), .wr_data_i(wr_data_i),
        .rd_stb_i(rd_stb_i), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
        .time_i(time_i), .osc_stop_i(osc_stop_i),
        .tk_load_o(tk_load_o), .tk_field_o(tk_field_o), .tk_data_o(tk_data_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_capture();
        for (int k = 0; k < 7; k++) m[k] = time_i[8*k +: 8];
    endtask

    task automatic model_advance();
        ptr = (ptr + 1) % 64;
        if (ptr == 0) model_capture();
    endtask

    // one cycle: drive at negedge, model, compare at next negedge
    task automatic step(input int kind, input logic [7:0] d, input string tag,
                        input bit both = 0);
        bit exp_rv = 0;
        logic [7:0] exp_rd = 8'h00;
        bit exp_tk = 0;
        int exp_f = 0;
        start_wr_i = (kind == K_SWR);
        start_rd_i = (kind == K_SRD);
        wr_stb_i   = (kind == K_WR) || both;
        rd_stb_i   = (kind == K_RD);
        osc_stop_i = (kind == K_OSC);
        wr_data_i  = d;
        case (kind)
            K_SWR: begin expect_addr = 1; model_capture(); end
            K_SRD: begin expect_addr = 0; model_capture(); end
            K_WR: begin
                if (expect_addr) begin
                    ptr = d & 8'h3F;
                    expect_addr = 0;
                end else begin
                    if (ptr < 7) begin
                        exp_tk = 1; exp_f = ptr;
                    end else if (ptr == 7) begin
                        m[7] = (d & 8'h93) | (d & m[7] & 8'h20);
                    end else begin
                        m[ptr] = d;
                    end
                    model_advance();
                end
            end
            K_RD: begin
                exp_rv = 1; exp_rd = m[ptr];
                model_advance();
            end
            K_OSC: m[7] = m[7] | 8'h20;
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        start_wr_i = 0; start_rd_i = 0; wr_stb_i = 0; rd_stb_i = 0; osc_stop_i = 0;
        check("R10 rd_valid", int'(rd_valid_o), int'(exp_rv));
        if (exp_rv) check(tag, int'(rd_data_o), int'(exp_rd));
        check("R8 tk_load", int'(tk_load_o), int'(exp_tk));
        if (exp_tk) begin
            check("R8 tk_field", int'(tk_field_o), exp_f);
            check("R8 tk_data", int'(tk_data_o), int'(d));
        end
    endtask

    task automatic set_ptr(input logic [7:0] a);
        step(K_SWR, 8'h00, "R2");
        step(K_WR, a, "R2");
    endtask

    task automatic read_n(input int n, input string tag);
        for (int i = 0; i < n; i++) step(K_RD, 8'h00, tag);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) m[i] = 8'h00;
        time_i = 56'h24_11_19_05_23_59_45;
        repeat (3) @(negedge clk);
        check("R1 rd_valid in reset", int'(rd_valid_o), 0);
        check("R1 tk_load in reset", int'(tk_load_o), 0);
        rst = 1'b0;
        step(K_IDLE, 8'h00, "R1");

        // R1: whole space readable as zero (time bytes show the capture)
        step(K_SRD, 8'h00, "R5");
        read_n(64, "R1 reset contents");

        // R2 + R9: address byte keeps low 6 bits; RAM stores as given
        set_ptr(8'h48);
        for (int i = 0; i < 12; i++) step(K_WR, 8'(8'hA0 + i * 7), "R9");
        set_ptr(8'h08);
        step(K_SRD, 8'h00, "R5");
        read_n(12, "R9 ram readback");

        // R6 + R7: control register behaviour
        set_ptr(8'h07);
        step(K_WR, 8'hFF, "R6");
        set_ptr(8'h07); step(K_SRD, 8'h00, "R5"); read_n(1, "R6 ctrl masked");
        step(K_OSC, 8'h00, "R7");
        set_ptr(8'h07); step(K_SRD, 8'h00, "R5"); read_n(1, "R7 stop set by monitor");
        set_ptr(8'h07); step(K_WR, 8'h20, "R7");
        set_ptr(8'h07); step(K_SRD, 8'h00, "R5"); read_n(1, "R7 write one keeps flag");
        set_ptr(8'h07); step(K_WR, 8'h00, "R7");
        set_ptr(8'h07); step(K_SRD, 8'h00, "R5"); read_n(1, "R7 write zero clears");

        // R8: time writes go to the timekeeper, snapshot untouched
        set_ptr(8'h00);
        for (int i = 0; i < 7; i++) step(K_WR, 8'(8'h11 * (i + 1)), "R8");
        time_i = 56'h30_12_31_07_22_58_59;
        set_ptr(8'h00);
        step(K_SRD, 8'h00, "R5");
        time_i = 56'h31_01_01_01_00_00_00;
        read_n(7, "R5 frozen snapshot");

        // R4: rollover on read refreshes the snapshot
        set_ptr(8'h3E);
        step(K_SRD, 8'h00, "R5");
        time_i = 56'h32_02_02_02_01_01_01;
        read_n(9, "R4 rollover on read");

        // R3/R4: rollover on write
        set_ptr(8'h3F);
        time_i = 56'h33_03_03_03_02_02_02;
        step(K_WR, 8'h5A, "R3");
        step(K_WR, 8'h01, "R3");
        set_ptr(8'h3F);
        step(K_SRD, 8'h00, "R5");
        read_n(3, "R3 wrap readback");

        // R11: start wins over a data strobe in the same cycle
        set_ptr(8'h20);
        step(K_WR, 8'h77, "R9");
        step(K_SWR, 8'hEE, "R11", 1'b1);
        step(K_WR, 8'h20, "R2");
        step(K_SRD, 8'h00, "R5");
        read_n(2, "R11 data strobe ignored");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule